// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block is the memory-device side of a synchronous DRAM column path. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable inputs together with the bank and address inputs. Read and write commands become bursts of column accesses into a small on-chip cell array that is indexed by bank, open row and column. A running burst walks its columns on consecutive cycles. The walk is either sequential or interleaved, and its length is 1, 2, 4 or 8 beats, or it runs without end over the whole page. Write data is taken on the same edges that issue the column addresses. Read data comes out after a programmable column latency of two or three cycles.

A controller uses it by opening a row in a bank, optionally loading a new burst mode while nothing is in flight, and then issuing column commands. Any new read or write replaces the running burst at once. A burst-stop command or a precharge of the burst's bank ends it. Read data that is already inside the latency pipeline is still delivered after the burst that produced it has been replaced or stopped.

Top module: `sdram_burst_seq`

## Requirements
- R1: Commands are decoded only when `cs_n` is low, from {`ras_n`,`cas_n`,`we_n`}: 011 open row, 010 close bank, 101 read, 100 write, 110 burst stop, 000 mode load, 111 no operation. The code 001 and any cycle with `cs_n` high do nothing.
- R2: After reset `dq_oe` and `cmd_err` are low, `dq_out` is zero, no bank is open, and the mode is four beats, sequential order, latency two.
- R3: A write beat stores `dq_in` into the cell addressed by the burst's bank, row and current column on the same edge that issues that column. The first beat is issued on the edge of the write command itself.
- R4: Read beat k of a burst whose command is sampled at edge 0 is driven on `dq_out` with `dq_oe` high during the cycle that ends at edge k+L, where L is 2 or 3.
- R5: In sequential order with length N, beat k uses column (start with its low log2(N) bits cleared) OR ((start + k) mod N).
- R6: In interleave order with length N, beat k uses column (start with its low log2(N) bits cleared) OR ((start XOR k) mod N).
- R7: Mode load takes `addr[2:0]` as length code (0:1, 1:2, 2:4, 3:8, 4 to 7: full page), `addr[3]` as order (1 = interleave) and `addr[4]` as latency (1 = three). A full-page burst steps through the page column by column in sequential order, wraps from the last column to column 0, and never ends by itself.
- R8: A read or write to an open bank on any edge replaces the running burst with a new one from its own start column. Read beats issued before that edge are still delivered at their latency.
- R9: A burst-stop command, or a close of the bank that the burst targets, issues no beat on its edge and ends the burst. Closing any other bank leaves the burst running.
- R10: A read or write to a bank with no open row is ignored, leaves any running burst untouched, and raises `cmd_err` for exactly the following cycle.
- R11: A mode load is ignored when a burst is running at its edge or when a read beat was issued on any of the three previous edges.
- R12: Whenever no read beat is due, `dq_oe` is low and `dq_out` is zero.
- R13: A fixed-length burst that is not interrupted issues exactly N beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W (2) | Bank select |
| addr | input | ADDR_W (5) | Row, start column, or mode fields depending on command |
| dq_in | input | DATA_W (8) | Write data |
| dq_out | output | DATA_W (8) | Read data, zero while not driving |
| dq_oe | output | 1 | High while a read beat is on `dq_out` |
| cmd_err | output | 1 | One-cycle flag for a column command to a closed bank |

## Verification
The hardest state to reach is a read burst replaced by a write while its earlier beats are still in the latency pipeline. In that state the output must keep delivering old read data while new write beats land in the array. The stimulus reaches it directly, with a write issued two edges after a read, and then repeatedly through a long random command stream over banks that are open and closed at random. A bench model follows every edge and compares the output bus, its enable and the error flag on every cycle. Full-page wrap and termination by bank close under latency three are driven as directed runs, because random stimulus rarely keeps a full-page burst alive long enough to wrap.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Default geometry of the modelled device
    localparam int unsigned SBS_BANK_W = 2;
    localparam int unsigned SBS_ROW_W  = 3;
    localparam int unsigned SBS_COL_W  = 4;
    localparam int unsigned SBS_DATA_W = 8;
    localparam int unsigned SBS_ADDR_W = 5;
    localparam int unsigned SBS_MAX_LAT = 3;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_OPEN,
        CMD_CLOSE,
        CMD_RD,
        CMD_WR,
        CMD_STOP,
        CMD_MODE,
        CMD_IGNORE
    } sbs_cmd_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       ilv;
        logic       cl3;
    } sbs_mode_t;

    localparam sbs_mode_t SBS_MODE_RESET = '{len_code: 3'd2, ilv: 1'b0, cl3: 1'b0};

    // Offset mask inside the aligned block for a fixed length code
    function automatic logic [15:0] sbs_len_mask(input logic [2:0] code);
        case (code[1:0])
            2'd0:    return 16'h0000;
            2'd1:    return 16'h0001;
            2'd2:    return 16'h0003;
            default: return 16'h0007;
        endcase
    endfunction

    // Column of beat k
    function automatic logic [15:0] sbs_beat_col(input logic [15:0] start,
                                                 input logic [15:0] k,
                                                 input logic [15:0] mask,
                                                 input logic        ilv,
                                                 input logic        full);
        logic [15:0] off;
        if (full) return start + k;
        off = ilv ? ((start ^ k) & mask) : ((start + k) & mask);
        return (start & ~mask) | off;
    endfunction

endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
    import sbs_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sbs_cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_OPEN;
                3'b010:  cmd = CMD_CLOSE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_STOP;
                3'b000:  cmd = CMD_MODE;
                3'b001:  cmd = CMD_IGNORE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sbs_bank_table.sv
module sbs_bank_table
    import sbs_pkg::*;
#(
    parameter int unsigned BANK_W = SBS_BANK_W,
    parameter int unsigned ROW_W  = SBS_ROW_W,
    localparam int unsigned NB    = 1 << BANK_W
) (
    input  logic                clk,
    input  logic                rst,
    input  sbs_cmd_e            cmd,
    input  logic [BANK_W-1:0]   ba,
    input  logic [ROW_W-1:0]    row_in,
    output logic [NB-1:0]       open_o,
    output logic [NB*ROW_W-1:0] rows_o
);

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic             hit;

        assign hit = (ba == BANK_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (hit && cmd == CMD_OPEN) begin
                open_q <= 1'b1;
                row_q  <= row_in;
            end else if (hit && cmd == CMD_CLOSE) begin
                open_q <= 1'b0;
            end
        end

        assign open_o[g]                  = open_q;
        assign rows_o[g*ROW_W +: ROW_W]   = row_q;
    end

endmodule

// File: rtl/sbs_burst_engine.sv
module sbs_burst_engine
    import sbs_pkg::*;
#(
    parameter int unsigned BANK_W = SBS_BANK_W,
    parameter int unsigned ROW_W  = SBS_ROW_W,
    parameter int unsigned COL_W  = SBS_COL_W,
    localparam int unsigned NB    = 1 << BANK_W
) (
    input  logic                clk,
    input  logic                rst,
    input  sbs_cmd_e            cmd,
    input  logic [BANK_W-1:0]   ba,
    input  logic [COL_W-1:0]    col_in,
    input  logic [NB-1:0]       bank_open,
    input  logic [NB*ROW_W-1:0] bank_rows,
    input  sbs_mode_t           mode,
    output logic                beat_v,
    output logic                beat_wr,
    output logic [BANK_W-1:0]   beat_bank,
    output logic [ROW_W-1:0]    beat_row,
    output logic [COL_W-1:0]    beat_col,
    output logic                active,
    output logic                col_reject
);

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  start;
        logic [COL_W-1:0]  k;
        logic [COL_W-1:0]  mask;
        logic              ilv;
        logic              full;
    } burst_t;

    burst_t      cur_q, src, nxt;
    logic        col_cmd, col_ok, term, last;
    logic [15:0] lmask, col16;

    assign col_cmd    = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign col_ok     = col_cmd && bank_open[ba];
    assign col_reject = col_cmd && !bank_open[ba];
    assign term       = (cmd == CMD_STOP) || (cmd == CMD_CLOSE && ba == cur_q.bank);
    assign lmask      = sbs_len_mask(mode.len_code);

    always_comb begin
        src    = cur_q;
        beat_v = 1'b0;
        if (col_ok) begin
            src.act   = 1'b1;
            src.wr    = (cmd == CMD_WR);
            src.bank  = ba;
            src.row   = bank_rows[ba*ROW_W +: ROW_W];
            src.start = col_in;
            src.k     = '0;
            src.mask  = lmask[COL_W-1:0];
            src.ilv   = mode.ilv;
            src.full  = mode.len_code[2];
            beat_v    = 1'b1;
        end else if (cur_q.act && !term) begin
            beat_v = 1'b1;
        end
        last = !src.full && (src.k == src.mask);
        nxt  = cur_q;
        if (beat_v) begin
            nxt     = src;
            nxt.k   = src.k + 1'b1;
            nxt.act = !last;
        end else begin
            nxt.act = 1'b0;
        end
        col16 = sbs_beat_col(16'(src.start), 16'(src.k), 16'(src.mask), src.ilv, src.full);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign beat_wr   = src.wr;
    assign beat_bank = src.bank;
    assign beat_row  = src.row;
    assign beat_col  = col16[COL_W-1:0];
    assign active    = cur_q.act;

endmodule

// File: rtl/sbs_read_pipe.sv
module sbs_read_pipe
    import sbs_pkg::*;
#(
    parameter int unsigned DATA_W  = SBS_DATA_W,
    parameter int unsigned MAX_LAT = SBS_MAX_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_v,
    input  logic [DATA_W-1:0] in_d,
    input  logic              long_lat,
    output logic              out_v,
    output logic [DATA_W-1:0] out_d,
    output logic              busy
);

    logic [MAX_LAT:1]  v_q;
    logic [DATA_W-1:0] d_q [1:MAX_LAT];
    int unsigned       tap;

    always_ff @(posedge clk) begin
        if (rst) v_q[1] <= 1'b0;
        else     v_q[1] <= in_v;
        d_q[1] <= in_d;
    end

    for (genvar g = 2; g <= MAX_LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) v_q[g] <= 1'b0;
            else     v_q[g] <= v_q[g-1];
            d_q[g] <= d_q[g-1];
        end
    end

    assign tap   = long_lat ? MAX_LAT : MAX_LAT - 1;
    assign out_v = v_q[tap];
    assign out_d = out_v ? d_q[tap] : '0;
    assign busy  = |v_q;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int unsigned BANK_W = SBS_BANK_W,
    parameter int unsigned ROW_W  = SBS_ROW_W,
    parameter int unsigned COL_W  = SBS_COL_W,
    parameter int unsigned DATA_W = SBS_DATA_W,
    parameter int unsigned ADDR_W = SBS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              cmd_err
);

    localparam int unsigned NB     = 1 << BANK_W;
    localparam int unsigned IDX_W  = BANK_W + ROW_W + COL_W;
    localparam int unsigned CELLS  = 1 << IDX_W;

    sbs_cmd_e          cmd_w;
    sbs_mode_t         mode_q;
    logic [NB-1:0]     bank_open;
    logic [NB*ROW_W-1:0] bank_rows;
    logic              beat_v, beat_wr, burst_active, col_reject, pipe_busy;
    logic [BANK_W-1:0] beat_bank;
    logic [ROW_W-1:0]  beat_row;
    logic [COL_W-1:0]  beat_col;
    logic [IDX_W-1:0]  cell_idx;
    logic [DATA_W-1:0] cell_rd;
    logic [DATA_W-1:0] cells_q [CELLS];

    sbs_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd_w)
    );

    sbs_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
        .clk (clk), .rst (rst), .cmd (cmd_w), .ba (ba),
        .row_in (addr[ROW_W-1:0]), .open_o (bank_open), .rows_o (bank_rows)
    );

    sbs_burst_engine #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_eng (
        .clk (clk), .rst (rst), .cmd (cmd_w), .ba (ba), .col_in (addr[COL_W-1:0]),
        .bank_open (bank_open), .bank_rows (bank_rows), .mode (mode_q),
        .beat_v (beat_v), .beat_wr (beat_wr), .beat_bank (beat_bank),
        .beat_row (beat_row), .beat_col (beat_col), .active (burst_active),
        .col_reject (col_reject)
    );

    // Cell array: one write port driven by write beats, one read port for read beats
    assign cell_idx = {beat_bank, beat_row, beat_col};
    assign cell_rd  = cells_q[cell_idx];

    always_ff @(posedge clk) begin
        if (beat_v && beat_wr) cells_q[cell_idx] <= dq_in;
    end

    sbs_read_pipe #(.DATA_W(DATA_W), .MAX_LAT(SBS_MAX_LAT)) u_pipe (
        .clk (clk), .rst (rst), .in_v (beat_v && !beat_wr), .in_d (cell_rd),
        .long_lat (mode_q.cl3), .out_v (dq_oe), .out_d (dq_out), .busy (pipe_busy)
    );

    // Mode register: only reloaded when nothing is in flight
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SBS_MODE_RESET;
        end else if (cmd_w == CMD_MODE && !burst_active && !pipe_busy) begin
            mode_q.len_code <= addr[2:0];
            mode_q.ilv      <= addr[3];
            mode_q.cl3      <= addr[4];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_err <= 1'b0;
        else     cmd_err <= col_reject;
    end

endmodule

// File: rtl/sbs_burst_seq_chk.sv
module sbs_burst_seq_chk
    import sbs_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input sbs_cmd_e  cmd_w,
    input logic      beat_v,
    input logic      beat_wr,
    input logic      burst_active,
    input sbs_mode_t mode_q,
    input logic      dq_oe,
    input logic      cmd_err
);

    logic rd_beat, col_cmd;
    assign rd_beat = beat_v && !beat_wr;
    assign col_cmd = (cmd_w == CMD_RD) || (cmd_w == CMD_WR);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!dq_oe && !cmd_err)); // R2

    AST_LAT_TWO: assert property (@(posedge clk) disable iff (rst)
        (rd_beat && !mode_q.cl3) |-> ##2 dq_oe); // R4

    AST_LAT_THREE: assert property (@(posedge clk) disable iff (rst)
        (rd_beat && mode_q.cl3) |-> ##3 dq_oe); // R4

    AST_OE_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (($past(rd_beat, 2) && !mode_q.cl3) || ($past(rd_beat, 3) && mode_q.cl3))); // R12

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_w == CMD_STOP) && !col_cmd) |-> !beat_v); // R9

    AST_ERR_FROM_COLUMN: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(col_cmd)); // R10

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(burst_active)) |-> $stable(mode_q)); // R11

endmodule

bind sdram_burst_seq sbs_burst_seq_chk u_chk (
    .clk (clk), .rst (rst), .cmd_w (cmd_w), .beat_v (beat_v), .beat_wr (beat_wr),
    .burst_active (burst_active), .mode_q (mode_q), .dq_oe (dq_oe), .cmd_err (cmd_err)
);

// File: tb/sim_sdram_burst_seq.sv
module sim_sdram_burst_seq;

    localparam int CLK_PERIOD = 10;

    localparam int C_NOP = 0, C_OPEN = 1, C_CLOSE = 2, C_RD = 3, C_WR = 4,
                   C_STOP = 5, C_MODE = 6, C_REF = 7, C_DESEL = 8, C_DESELX = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [4:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe, cmd_err;

    int errors = 0;
    int checks = 0;
    int oe_seen = 0;
    bit done = 0;
    string cur_req = "R2";

    // Bench model
    logic [7:0] mem_m [512];
    bit   open_m [4];
    int   row_m [4];
    int   m_len, m_ilvm, m_cl3;
    bit   m_act, m_wr, m_ilv, m_full;
    int   m_bank, m_row, m_start, m_k, m_mask;
    bit   p_v [1:3];
    logic [7:0] p_d [1:3];
    bit   err_m;

    sdram_burst_seq u0 (
        .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .ba (ba), .addr (addr), .dq_in (dq_in), .dq_out (dq_out),
        .dq_oe (dq_oe), .cmd_err (cmd_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] strobes(input int c);
        case (c)
            C_OPEN:   return 4'b0011;
            C_CLOSE:  return 4'b0010;
            C_RD:     return 4'b0101;
            C_WR:     return 4'b0100;
            C_STOP:   return 4'b0110;
            C_MODE:   return 4'b0000;
            C_REF:    return 4'b0001;
            C_DESEL:  return 4'b1111;
            C_DESELX: return 4'b1000;
            default:  return 4'b0111;
        endcase
    endfunction

    function automatic int mask_of(input int code);
        case (code % 4)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 7;
        endcase
    endfunction

    function automatic int bcol(input int s, input int k, input int mask, input bit ilv, input bit full);
        if (full) return (s + k) % 16;
        if (ilv)  return (s & ~mask) | ((s ^ k) & mask);
        return (s & ~mask) | ((s + k) & mask);
    endfunction

    function automatic logic [7:0] fill_val(input int b, input int r, input int c);
        return 8'((b * 64 + r * 16 + c) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin open_m[i] = 0; row_m[i] = 0; end
        m_len = 2; m_ilvm = 0; m_cl3 = 0;
        m_act = 0; m_wr = 0; m_ilv = 0; m_full = 0;
        m_bank = 0; m_row = 0; m_start = 0; m_k = 0; m_mask = 0;
        for (int i = 1; i <= 3; i++) begin p_v[i] = 0; p_d[i] = '0; end
        err_m = 0;
    endtask

    task automatic model_edge(input int c, input int b, input int a, input logic [7:0] d);
        bit col, ok, bad, term, busy, bv, bw;
        int idx;
        logic [7:0] rd;
        col  = (c == C_RD) || (c == C_WR);
        ok   = col && open_m[b];
        bad  = col && !open_m[b];
        term = (c == C_STOP) || (c == C_CLOSE && b == m_bank);
        busy = m_act || p_v[1] || p_v[2] || p_v[3];
        bv = 0; bw = 0; idx = 0; rd = '0;
        if (ok) begin
            m_wr = (c == C_WR); m_bank = b; m_row = row_m[b]; m_start = a % 16;
            m_k = 0; m_mask = mask_of(m_len); m_ilv = m_ilvm[0]; m_full = (m_len >= 4);
            bv = 1;
        end else if (m_act && !term) begin
            bv = 1;
        end
        if (bv) begin
            idx = m_bank * 128 + m_row * 16 + bcol(m_start, m_k, m_mask, m_ilv, m_full);
            rd = mem_m[idx];
            bw = m_wr;
        end
        p_v[3] = p_v[2]; p_d[3] = p_d[2];
        p_v[2] = p_v[1]; p_d[2] = p_d[1];
        p_v[1] = bv && !bw; p_d[1] = rd;
        if (bv && bw) mem_m[idx] = d;
        if (bv) begin
            m_act = m_full || (m_k != m_mask);
            m_k = (m_k + 1) % 16;
        end else begin
            m_act = 0;
        end
        if (c == C_OPEN)  begin open_m[b] = 1; row_m[b] = a % 8; end
        if (c == C_CLOSE) open_m[b] = 0;
        if (c == C_MODE && !busy) begin m_len = a % 8; m_ilvm = (a >> 3) & 1; m_cl3 = (a >> 4) & 1; end
        err_m = bad;
    endtask

    task automatic compare();
        bit eoe;
        eoe = m_cl3 ? p_v[3] : p_v[2];
        if (dq_oe === 1'b1) oe_seen++;
        chk(dq_oe === eoe, {cur_req, " R4 R12 oe"}, int'(dq_oe), int'(eoe));
        if (eoe) chk(dq_out === (m_cl3 ? p_d[3] : p_d[2]), {cur_req, " R3 R4 data"},
                     int'(dq_out), int'(m_cl3 ? p_d[3] : p_d[2]));
        else     chk(dq_out === 8'h00, {cur_req, " R12 idle bus"}, int'(dq_out), 0);
        chk(cmd_err === err_m, {cur_req, " R10 err"}, int'(cmd_err), int'(err_m));
    endtask

    task automatic tick(input int c, input int b, input int a, input logic [7:0] d);
        {cs_n, ras_n, cas_n, we_n} = strobes(c);
        ba = 2'(b); addr = 5'(a); dq_in = d;
        model_edge(c, b, a, d);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(C_NOP, 0, 0, 8'h00);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog act=running exp=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd4711);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        cur_req = "R2";
        chk(dq_oe === 1'b0, "R2 oe after reset", int'(dq_oe), 0);
        chk(cmd_err === 1'b0, "R2 err after reset", int'(cmd_err), 0);
        chk(dq_out === 8'h00, "R2 bus after reset", int'(dq_out), 0);

        // R2 R3 R5: default mode (4 beats sequential, latency 2) write then read
        tick(C_OPEN, 0, 0, 0);
        tick(C_WR, 0, 1, 8'hA1);
        tick(C_NOP, 0, 0, 8'hA2);
        tick(C_NOP, 0, 0, 8'hA3);
        tick(C_NOP, 0, 0, 8'hA4);
        idle(2);
        oe_seen = 0;
        tick(C_RD, 0, 1, 0);
        tick(C_NOP, 0, 0, 0);
        chk(dq_oe === 1'b1 && dq_out === 8'hA1, "R4 first beat at latency two", int'(dq_out), 8'hA1);
        idle(6);
        chk(oe_seen == 4, "R2 default length beats", oe_seen, 4);
        tick(C_CLOSE, 0, 0, 0);

        // R3 R7: fill every page with full-page write bursts
        cur_req = "R3 R7";
        tick(C_MODE, 0, 7, 0);
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 8; r++) begin
                tick(C_OPEN, b, r, 0);
                tick(C_WR, b, 0, fill_val(b, r, 0));
                for (int c = 1; c < 16; c++) tick(C_NOP, 0, 0, fill_val(b, r, c));
                tick(C_STOP, 0, 0, 0);
                tick(C_CLOSE, b, 0, 0);
            end
        end

        // R5: sequential length 4 from column 6
        cur_req = "R5";
        tick(C_MODE, 0, 2, 0);
        tick(C_OPEN, 0, 2, 0);
        oe_seen = 0;
        tick(C_RD, 0, 6, 0);
        tick(C_NOP, 0, 0, 0);
        chk(dq_out === fill_val(0, 2, 6), "R5 beat0 column 6", int'(dq_out), int'(fill_val(0, 2, 6)));
        tick(C_NOP, 0, 0, 0);
        chk(dq_out === fill_val(0, 2, 7), "R5 beat1 column 7", int'(dq_out), int'(fill_val(0, 2, 7)));
        tick(C_NOP, 0, 0, 0);
        chk(dq_out === fill_val(0, 2, 4), "R5 beat2 wraps to column 4", int'(dq_out), int'(fill_val(0, 2, 4)));
        idle(4);
        chk(oe_seen == 4, "R5 beat count", oe_seen, 4);

        // R6: interleave length 8, latency 3
        cur_req = "R6";
        tick(C_MODE, 0, 27, 0);
        oe_seen = 0;
        tick(C_RD, 0, 5, 0);
        tick(C_NOP, 0, 0, 0);
        tick(C_NOP, 0, 0, 0);
        chk(dq_out === fill_val(0, 2, 5), "R6 beat0 column 5", int'(dq_out), int'(fill_val(0, 2, 5)));
        tick(C_NOP, 0, 0, 0);
        chk(dq_out === fill_val(0, 2, 4), "R6 beat1 column 4", int'(dq_out), int'(fill_val(0, 2, 4)));
        tick(C_NOP, 0, 0, 0);
        chk(dq_out === fill_val(0, 2, 7), "R6 beat2 column 7", int'(dq_out), int'(fill_val(0, 2, 7)));
        idle(9);
        chk(oe_seen == 8, "R6 beat count", oe_seen, 8);

        // R13: lengths 1, 2, 8
        cur_req = "R13";
        tick(C_MODE, 0, 0, 0);
        oe_seen = 0; tick(C_RD, 0, 3, 0); idle(5);
        chk(oe_seen == 1, "R13 length one", oe_seen, 1);
        tick(C_MODE, 0, 1, 0);
        oe_seen = 0; tick(C_RD, 0, 3, 0); idle(5);
        chk(oe_seen == 2, "R13 length two", oe_seen, 2);
        tick(C_MODE, 0, 3, 0);
        oe_seen = 0; tick(C_RD, 0, 3, 0); idle(11);
        chk(oe_seen == 8, "R13 length eight", oe_seen, 8);

        // R7: full page wraps until stop
        cur_req = "R7";
        tick(C_MODE, 0, 7, 0);
        oe_seen = 0;
        tick(C_RD, 0, 14, 0);
        idle(40);
        tick(C_STOP, 0, 0, 0);
        idle(5);
        chk(oe_seen == 41, "R7 full page beats before stop", oe_seen, 41);

        // R9: full page latency 3 ended by closing its bank
        cur_req = "R9";
        tick(C_MODE, 0, 23, 0);
        oe_seen = 0;
        tick(C_RD, 0, 3, 0);
        idle(9);
        tick(C_CLOSE, 0, 0, 0);
        idle(6);
        chk(oe_seen == 10, "R9 close ends full page", oe_seen, 10);
        tick(C_MODE, 0, 3, 0);
        tick(C_OPEN, 0, 1, 0);
        tick(C_OPEN, 1, 0, 0);
        oe_seen = 0;
        tick(C_RD, 0, 0, 0);
        tick(C_NOP, 0, 0, 0);
        tick(C_CLOSE, 1, 0, 0);
        idle(10);
        chk(oe_seen == 8, "R9 other bank close no effect", oe_seen, 8);
        oe_seen = 0;
        tick(C_RD, 0, 0, 0);
        tick(C_NOP, 0, 0, 0);
        tick(C_STOP, 0, 0, 0);
        idle(5);
        chk(oe_seen == 2, "R9 stop after two beats", oe_seen, 2);

        // R8: interruptions
        cur_req = "R8";
        tick(C_MODE, 0, 2, 0);
        oe_seen = 0;
        tick(C_RD, 0, 0, 0);
        tick(C_NOP, 0, 0, 0);
        tick(C_RD, 0, 9, 0);
        idle(7);
        chk(oe_seen == 6, "R8 read interrupts read", oe_seen, 6);
        oe_seen = 0;
        tick(C_RD, 0, 4, 0);
        tick(C_NOP, 0, 0, 0);
        tick(C_WR, 0, 12, 8'h5A);
        tick(C_NOP, 0, 0, 8'h5B);
        tick(C_NOP, 0, 0, 8'h5C);
        tick(C_NOP, 0, 0, 8'h5D);
        idle(3);
        chk(oe_seen == 2, "R8 pipelined reads survive write", oe_seen, 2);
        tick(C_RD, 0, 13, 0);
        tick(C_NOP, 0, 0, 0);
        chk(dq_out === 8'h5B, "R8 write data from new start", int'(dq_out), 8'h5B);
        idle(5);

        // R10: column command to a closed bank
        cur_req = "R10";
        tick(C_MODE, 0, 3, 0);
        tick(C_CLOSE, 2, 0, 0);
        oe_seen = 0;
        tick(C_RD, 0, 0, 0);
        tick(C_NOP, 0, 0, 0);
        tick(C_RD, 2, 3, 0);
        chk(cmd_err === 1'b1, "R10 flag raised", int'(cmd_err), 1);
        tick(C_NOP, 0, 0, 0);
        chk(cmd_err === 1'b0, "R10 flag one cycle", int'(cmd_err), 0);
        idle(9);
        chk(oe_seen == 8, "R10 burst untouched", oe_seen, 8);

        // R11: mode load ignored while busy
        cur_req = "R11";
        tick(C_RD, 0, 0, 0);
        tick(C_NOP, 0, 0, 0);
        tick(C_MODE, 0, 0, 0);
        idle(10);
        oe_seen = 0;
        tick(C_RD, 0, 0, 0);
        idle(11);
        chk(oe_seen == 8, "R11 length kept after busy load", oe_seen, 8);

        // R1: ignored command codes while a burst runs
        cur_req = "R1";
        oe_seen = 0;
        tick(C_RD, 0, 0, 0);
        tick(C_REF, 0, 0, 0);
        tick(C_DESEL, 0, 0, 0);
        tick(C_DESELX, 0, 0, 0);
        idle(9);
        chk(oe_seen == 8, "R1 ignored codes leave burst", oe_seen, 8);

        // Random command stream
        cur_req = "R1 R8 R9";
        for (int i = 0; i < 3000; i++) begin
            int r, c;
            r = int'($urandom % 100);
            if      (r < 25) c = C_RD;
            else if (r < 45) c = C_WR;
            else if (r < 60) c = C_OPEN;
            else if (r < 70) c = C_CLOSE;
            else if (r < 78) c = C_STOP;
            else if (r < 81) c = C_MODE;
            else if (r < 84) c = C_REF;
            else if (r < 86) c = C_DESELX;
            else             c = C_NOP;
            tick(c, int'($urandom % 4), int'($urandom % 32), 8'($urandom));
        end
        idle(6);

        done = 1;
        summary();
        $finish;
    end

endmodule